// File: doc/BRIEF.md
# Cache Block Refill Sequencer

This block runs the refill of one cache block after a miss. A requester raises a miss request with the block address. The sequencer puts that address on the memory side for exactly one clock. It then takes each word that the memory returns and writes it straight into the cache data array at its word offset. The offsets start at zero and rise with every arrival. The processor pipeline stays stalled for the whole refill. The stall is released only after the last word of the block is in the array. Releasing it at the critical word would let a store to a later word of the block be overwritten by refill data that is still arriving.

Two memory organisations are supported, chosen by a parameter. The banked memory returns four words on consecutive clocks, then leaves a gap of six clocks before the next group. The wide memory returns four words together once every ten clocks, through a four-word write lane. When the stall drops, the sequencer raises a one-clock completion pulse. It also reports the miss penalty in clocks, which is the number of clocks the stall was held. Clock 1 is the address clock. With the banked timing, words land on clocks 10–13, 20–23, 30–33 and 40–43, so the penalty is 43. With the wide timing, words land on clocks 10, 20, 30 and 40, so the penalty is 40.

Top module: `refill_seq`

## Requirements
- R1: After a synchronous active-high reset, or after a reset applied in the middle of a refill, stall, busy, mem_req, cw_en and done are low and penalty is 0.
- R2: A miss request seen at a clock edge while the sequencer is idle makes mem_req high for exactly the next clock, with mem_addr equal to the requested address. From that clock onward, stall and busy are high.
- R3: Each word that memory returns during a refill is written in the same clock. cw_en is high, cw_off is the word offset, and cw_data is the returned data. Offsets start at 0 and rise by one per arrival (banked) or by four per beat (wide). In the wide mode, lane i of cw_data holds word cw_off+i.
- R4: Every one of the 16 word offsets is written exactly once per refill.
- R5: In the banked mode, stall stays high until the clock in which the 16th word is written, and it is low in the clock after that: 43 clocks of stall.
- R6: In the wide mode, the four beats are written as lanes of four words, and stall is held for 40 clocks.
- R7: In the clock after the last write, done is high for one clock and penalty equals the number of stall clocks. penalty holds that value until the next completion.
- R8: A miss request that arrives while busy is high is ignored. It produces no extra address clock and does not shift the refill timing. A request held high in the completion clock starts the next refill.
- R9: Memory valid seen while idle or during the address clock writes nothing: cw_en stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_req | input | 1 | Miss request from the cache |
| miss_addr | input | ADDR_W | Block address of the miss |
| mem_rvalid | input | 1 | Memory returns data this clock |
| mem_rdata | input | LANES*DATA_W | Returned word(s), lane 0 in the low bits |
| busy | output | 1 | Refill in progress; new requests are ignored |
| stall | output | 1 | Hold the processor pipeline |
| mem_req | output | 1 | Address clock to memory |
| mem_addr | output | ADDR_W | Block address sent to memory |
| cw_en | output | 1 | Cache data array write enable |
| cw_off | output | log2(WORDS) | Word offset of lane 0 of the write |
| cw_data | output | LANES*DATA_W | Data written to the cache array |
| done | output | 1 | One-clock completion pulse |
| penalty | output | PEN_W | Miss penalty in clocks of the last refill |

## Verification
The bench runs a banked and a wide instance side by side against a timing model of each memory. The model also returns false valid cycles before the refill begins. A sequencer that wrote those cycles into the array would show a write outside the refill window, or a word written twice. The bench sends repeated requests in the middle of a refill and a request held high across completions. A design that restarted on those requests would issue a second address clock. A design that failed to rearm in the completion clock would miss the next refill. The bench counts the exact clock on which the stall drops in each mode. An early release, for example at the critical word or one clock short, shows up as a stall mismatch and a wrong penalty. A reset in the middle of a refill must clear both the outputs and the reported penalty.

// File: rtl/refill_pkg.sv
package refill_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_FILL
    } refill_st_e;
endpackage

// File: rtl/refill_off_ctr.sv
module refill_off_ctr #(
    parameter int WORDS = 16,
    parameter int LANES = 1,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    output logic [OFF_W-1:0] off,
    output logic             last
);
    logic [OFF_W-1:0] off_d, off_q;

    always_comb begin
        off_d = off_q;
        if (clr) begin
            off_d = '0;
        end else if (adv) begin
            off_d = off_q + OFF_W'(LANES);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q <= '0;
        end else begin
            off_q <= off_d;
        end
    end

    assign off  = off_q;
    assign last = (off_q == OFF_W'(WORDS - LANES));
endmodule

// File: rtl/refill_pen_ctr.sv
module refill_pen_ctr #(
    parameter int PEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic             cap,
    output logic [PEN_W-1:0] penalty
);
    typedef struct packed {
        logic [PEN_W-1:0] cnt;
        logic [PEN_W-1:0] pen;
    } pen_t;

    pen_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (start) begin
            nxt_d.cnt = PEN_W'(1);
        end else if (run && (cur_q.cnt != '1)) begin
            nxt_d.cnt = cur_q.cnt + PEN_W'(1);
        end
        if (cap) begin
            nxt_d.pen = cur_q.cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign penalty = cur_q.pen;
endmodule

// File: rtl/refill_seq.sv
module refill_seq
    import refill_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WORDS  = 16,
    parameter int GROUP  = 4,
    parameter bit WIDE   = 1'b0,
    parameter int PEN_W  = 8,
    localparam int LANES = WIDE ? GROUP : 1,
    localparam int OFF_W = $clog2(WORDS),
    localparam int BUS_W = LANES * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_req,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              mem_rvalid,
    input  logic [BUS_W-1:0]  mem_rdata,
    output logic              busy,
    output logic              stall,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              cw_en,
    output logic [OFF_W-1:0]  cw_off,
    output logic [BUS_W-1:0]  cw_data,
    output logic              done,
    output logic [PEN_W-1:0]  penalty
);
    typedef struct packed {
        refill_st_e        st;
        logic [ADDR_W-1:0] addr;
        logic              done;
    } seq_t;

    seq_t cur_q, nxt_d;
    logic accept, wr, last, active;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        accept     = 1'b0;
        wr         = 1'b0;
        case (cur_q.st)
            ST_IDLE: begin
                if (miss_req) begin
                    accept     = 1'b1;
                    nxt_d.st   = ST_ADDR;
                    nxt_d.addr = miss_addr;
                end
            end
            ST_ADDR: begin
                nxt_d.st = ST_FILL;
            end
            ST_FILL: begin
                if (mem_rvalid) begin
                    wr = 1'b1;
                    if (last) begin
                        nxt_d.st   = ST_IDLE;
                        nxt_d.done = 1'b1;
                    end
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{st: ST_IDLE, addr: '0, done: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign active = (cur_q.st != ST_IDLE);

    refill_off_ctr #(
        .WORDS (WORDS),
        .LANES (LANES)
    ) u_off (
        .clk  (clk),
        .rst  (rst),
        .clr  (accept),
        .adv  (wr),
        .off  (cw_off),
        .last (last)
    );

    refill_pen_ctr #(
        .PEN_W (PEN_W)
    ) u_pen (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .run     (active),
        .cap     (wr && last),
        .penalty (penalty)
    );

    assign busy     = active;
    assign stall    = active;
    assign mem_req  = (cur_q.st == ST_ADDR);
    assign mem_addr = cur_q.addr;
    assign cw_en    = wr;
    assign cw_data  = mem_rdata;
    assign done     = cur_q.done;
endmodule

// File: rtl/refill_seq_chk.sv
module refill_seq_chk (
    input logic clk,
    input logic rst,
    input logic miss_req,
    input logic busy,
    input logic stall,
    input logic mem_req,
    input logic cw_en,
    input logic done
);
    p_req_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    p_req_stalled_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> stall);

    p_write_in_fill_r3: assert property (@(posedge clk) disable iff (rst)
        cw_en |-> (stall && !mem_req));

    p_release_done_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(stall) |-> done);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !stall);

    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && miss_req) |=> !mem_req);

    p_idle_no_write_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !cw_en);
endmodule

bind refill_seq refill_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .miss_req (miss_req),
    .busy     (busy),
    .stall    (stall),
    .mem_req  (mem_req),
    .cw_en    (cw_en),
    .done     (done)
);

// File: tb/refill_seq_tb.sv
`timescale 1ns/1ps
module refill_seq_tb;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst, miss_req;
    logic [31:0] miss_addr;
    logic        rv0, rv1;
    logic [31:0] rd0;
    logic [127:0] rd1;

    logic        busy0, stall0, mreq0, cwen0, done0;
    logic [31:0] maddr0, cwd0;
    logic [3:0]  cwoff0;
    logic [7:0]  pen0;
    logic        busy1, stall1, mreq1, cwen1, done1;
    logic [31:0] maddr1;
    logic [127:0] cwd1;
    logic [3:0]  cwoff1;
    logic [7:0]  pen1;

    refill_seq #(.WIDE(1'b0)) u_dut (
        .clk(clk), .rst(rst), .miss_req(miss_req), .miss_addr(miss_addr),
        .mem_rvalid(rv0), .mem_rdata(rd0), .busy(busy0), .stall(stall0),
        .mem_req(mreq0), .mem_addr(maddr0), .cw_en(cwen0), .cw_off(cwoff0),
        .cw_data(cwd0), .done(done0), .penalty(pen0));

    refill_seq #(.WIDE(1'b1)) u_dut_wide (
        .clk(clk), .rst(rst), .miss_req(miss_req), .miss_addr(miss_addr),
        .mem_rvalid(rv1), .mem_rdata(rd1), .busy(busy1), .stall(stall1),
        .mem_req(mreq1), .mem_addr(maddr1), .cw_en(cwen1), .cw_off(cwoff1),
        .cw_data(cwd1), .done(done1), .penalty(pen1));

    int n_cmp = 0;
    int n_bad = 0;
    int k [2];
    int pen_exp [2];
    logic [31:0] raddr [2];
    bit wr [2][16];
    bit prev_req, prev_rst;
    logic [31:0] prev_addr;
    bit srst, sreq;
    logic [31:0] saddr;
    bit arr [2];
    int offx [2];
    logic [127:0] drv [2];

    function automatic logic [31:0] wval(logic [31:0] a, int i);
        return {a[19:0], 8'hA5, 4'(i)};
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_mode(input int m, input logic bz, input logic st, input logic mq,
                              input logic [31:0] ma, input logic ce, input logic [3:0] co,
                              input logic [127:0] cd, input logic dn, input logic [7:0] pn);
        int last = (m == 1) ? 40 : 43;
        bit eb = (k[m] >= 1) && (k[m] <= last);
        if (prev_rst) begin
            chk("R1 reset outputs", 128'({st, bz, mq, ce, dn, pn}), 128'(0));
        end
        chk(m == 1 ? "R6 stall" : "R5 stall", 128'(st), 128'(eb));
        chk("R8 busy", 128'(bz), 128'(eb));
        chk("R2 R8 mem_req", 128'(mq), 128'(k[m] == 1));
        if (k[m] == 1) chk("R2 mem_addr", 128'(ma), 128'(raddr[m]));
        chk(k[m] <= 1 ? "R9 cw_en" : "R3 cw_en", 128'(ce), 128'(arr[m]));
        if (arr[m] && ce) begin
            chk("R3 cw_off", 128'(co), 128'(offx[m]));
            chk("R3 cw_data", cd, drv[m]);
            for (int l = 0; l < (m == 1 ? 4 : 1); l++) begin
                if (wr[m][offx[m] + l]) chk("R4 word written twice", 128'(1), 128'(0));
                wr[m][offx[m] + l] = 1'b1;
            end
        end
        chk("R7 done", 128'(dn), 128'(k[m] == last + 1));
        if (k[m] == last + 1) begin
            int cnt = 0;
            for (int w = 0; w < 16; w++) cnt += int'(wr[m][w]);
            chk("R4 words written", 128'(cnt), 128'(16));
            chk(m == 1 ? "R6 R7 penalty" : "R5 R7 penalty", 128'(pn), 128'(last));
            pen_exp[m] = last;
        end else begin
            chk("R7 penalty hold", 128'(pn), 128'(pen_exp[m]));
        end
    endtask

    task automatic step();
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            int last = (m == 1) ? 40 : 43;
            if (prev_rst) begin
                k[m] = 0;
                pen_exp[m] = 0;
            end else if (prev_req && (k[m] == 0 || k[m] == last + 1)) begin
                k[m] = 1;
                raddr[m] = prev_addr;
                for (int w = 0; w < 16; w++) wr[m][w] = 1'b0;
            end else if (k[m] >= 1 && k[m] <= last) begin
                k[m] = k[m] + 1;
            end else begin
                k[m] = 0;
            end
            if (m == 0) begin
                arr[m]  = (k[m] >= 10) && (k[m] <= 43) && ((k[m] % 10) < 4);
                offx[m] = (k[m] / 10 - 1) * 4 + (k[m] % 10);
            end else begin
                arr[m]  = (k[m] >= 10) && (k[m] <= 40) && ((k[m] % 10) == 0);
                offx[m] = (k[m] / 10 - 1) * 4;
            end
            drv[m] = {wval(raddr[m], offx[m] + 3), wval(raddr[m], offx[m] + 2),
                      wval(raddr[m], offx[m] + 1), wval(raddr[m], offx[m])};
            if (m == 0) drv[m] = {96'b0, wval(raddr[m], offx[m])};
            if (!arr[m]) drv[m] = {4{32'hDEAD_BEEF}};
        end
        rv0 = arr[0] || (k[0] <= 1);
        rv1 = arr[1] || (k[1] <= 1);
        rd0 = drv[0][31:0];
        rd1 = drv[1];
        rst = srst;
        miss_req = sreq;
        miss_addr = saddr;
        #1;
        if (!rst) begin
            check_mode(0, busy0, stall0, mreq0, maddr0, cwen0, cwoff0, {96'b0, cwd0}, done0, pen0);
            check_mode(1, busy1, stall1, mreq1, maddr1, cwen1, cwoff1, cwd1, done1, pen1);
        end
        prev_req = miss_req;
        prev_addr = miss_addr;
        prev_rst = rst;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; miss_req = 1'b0; miss_addr = '0;
        rv0 = 1'b0; rv1 = 1'b0; rd0 = '0; rd1 = '0;
        k[0] = 0; k[1] = 0; pen_exp[0] = 0; pen_exp[1] = 0;
        raddr[0] = '0; raddr[1] = '0;
        prev_req = 1'b0; prev_rst = 1'b1; prev_addr = '0;
        srst = 1'b1; sreq = 1'b0; saddr = 32'h0;
        repeat (3) step();
        srst = 1'b0;
        repeat (3) step();
        // R2: single request, then R8: requests while busy
        sreq = 1'b1; saddr = 32'h0001_2340; step(); sreq = 1'b0;
        repeat (5) step();
        sreq = 1'b1; saddr = 32'h0BAD_0000; repeat (3) step(); sreq = 1'b0;
        repeat (20) step();
        sreq = 1'b1; saddr = 32'h0777_7770; step(); sreq = 1'b0;
        repeat (30) step();
        // R8: request held high across completions, address changes mid-run
        sreq = 1'b1; saddr = 32'h00AB_CD00; repeat (50) step();
        saddr = 32'h0055_AA00; repeat (60) step();
        sreq = 1'b0; repeat (50) step();
        // R1: reset in the middle of a refill
        sreq = 1'b1; saddr = 32'h0F0F_0F00; step(); sreq = 1'b0;
        repeat (15) step();
        srst = 1'b1; repeat (2) step(); srst = 1'b0;
        repeat (4) step();
        sreq = 1'b1; saddr = 32'h0123_4560; step(); sreq = 1'b0;
        repeat (50) step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule